// File: doc/BRIEF.md
# Parallel Port Bank with Edge Interrupt

A byte-wide register block that gives a controller 32 general-purpose pins, in four groups of eight. Three groups are bidirectional. Each has an output latch and a direction register that makes each pin an output (1) or an input (0). The fourth group is input only. One of its bits, IRQ_BIT (bit 6 by default), also raises an interrupt request on a falling edge once that request is enabled.

All pin inputs pass through a two-stage synchronizer before they are read or used for edge detection. Reads are combinational from the address. Writes take effect on the clock edge that samples the write strobe. The direction registers cannot be read back; they always return all ones. Addresses 8 and above in the I/O window are unimplemented.

Address map (ADDR_W bits): 0, 1, 2 are the data registers of bidirectional ports 0, 1, 2; 3 is the input-only port; 4, 5, 6 are the direction registers of ports 0, 1, 2; 7 is the control register, with bit 0 enable and bit 1 pending.

Top module: `pport_bank`

## Requirements
- R1: After reset, every output latch and every direction bit is 0, `io_out`, `io_oe` and `irq` are 0, and address 7 reads 0x00.
- R2: A write to address k (k = 0, 1, 2) appears on `io_out[k]` from the next clock edge. A write to address 4+k appears on `io_oe[k]` from the next clock edge, where 1 means output.
- R3: A read of address k (k = 0, 1, 2) returns the output latch in bits whose direction is 1. It returns the pin level in bits whose direction is 0, and that level is visible on the second rising edge after the pin changes, not the first.
- R4: A read of address 4, 5 or 6 returns 0xFF whatever was written there.
- R5: A read of address 3 returns the synchronized input-only pins. A write to address 3 changes no output, no direction and no readable state.
- R6: Address 7 reads bit 0 = enable, bit 1 = pending, and all other bits 0. When enable is 1, a high-to-low transition of `in_pins[IRQ_BIT]` sets pending. `irq` equals enable AND pending.
- R7: Writing address 7 with bit 1 = 0 clears pending. Writing it with bit 1 = 1 leaves pending unchanged.
- R8: A rising edge on `in_pins[IRQ_BIT]` never sets pending. A falling edge while enable is 0 does not set pending either.
- R9: If a falling edge is detected in the same cycle as a write that clears pending, pending ends up set.
- R10: Addresses 8 to 15 read 0x00, and a write to them changes no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wdata | input | W | Write data |
| we | input | 1 | Write strobe, sampled at the rising edge |
| rdata | output | W | Read data for `addr`, combinational |
| io_in | input | 3×W | Pin levels of bidirectional ports 0..2 |
| in_pins | input | W | Pin levels of the input-only port |
| io_out | output | 3×W | Output latch values of ports 0..2 |
| io_oe | output | 3×W | Per-pin output enables of ports 0..2 |
| irq | output | 1 | Interrupt request from `in_pins[IRQ_BIT]` |

## Verification
Register writes are visible on the ports one rising edge after the strobe is sampled, and reads are combinational. The bench therefore drives at the falling edge and samples shortly after the next falling edge. A pin change becomes readable two rising edges later, and the bench reads after one edge and after two to pin this down. A falling interrupt edge sets pending on the third rising edge after the pin moves. The race test places its clearing write on exactly that edge, and the other interrupt checks wait four cycles before reading.

// File: rtl/pport_bank.sv
module pport_bank #(
  parameter int W       = 8,
  parameter int ADDR_W  = 4,
  parameter int IRQ_BIT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [W-1:0]         wdata,
  input  logic                 we,
  output logic [W-1:0]         rdata,
  input  logic [2:0][W-1:0]    io_in,
  input  logic [W-1:0]         in_pins,
  output logic [2:0][W-1:0]    io_out,
  output logic [2:0][W-1:0]    io_oe,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] A_INP  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(7);

  logic [W-1:0] dat [3];
  logic [W-1:0] dir [3];
  logic [3:0][W-1:0] s1, s2;
  logic prev, en, pend, fall;
  logic [W-1:0] rd_port [3];

  assign fall = prev & ~s2[3][IRQ_BIT];
  assign irq  = en & pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prev <= 1'b0;
    end else begin
      s1 <= {in_pins, io_in};
      s2 <= s1;
      prev <= s2[3][IRQ_BIT];
    end

  for (genvar k = 0; k < 3; k++) begin : g_port
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        dat[k] <= '0;
        dir[k] <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(k))     dat[k] <= wdata;
        if (addr == ADDR_W'(k + 4)) dir[k] <= wdata;
      end
    assign io_out[k]  = dat[k];
    assign io_oe[k]   = dir[k];
    assign rd_port[k] = (dat[k] & dir[k]) | (s2[k] & ~dir[k]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en   <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (we && addr == A_CTRL) begin
        en <= wdata[0];
        if (!wdata[1]) pend <= 1'b0;
      end
      if (fall && en) pend <= 1'b1;
    end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(0): rdata = rd_port[0];
      ADDR_W'(1): rdata = rd_port[1];
      ADDR_W'(2): rdata = rd_port[2];
      A_INP:      rdata = s2[3];
      ADDR_W'(4), ADDR_W'(5), ADDR_W'(6): rdata = '1;
      A_CTRL:     rdata = {{(W-2){1'b0}}, pend, en};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/pport_bank_chk.sv
module pport_bank_chk #(
  parameter int W      = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic              we,
  input logic [W-1:0]      rdata,
  input logic [2:0][W-1:0] io_out,
  input logic [2:0][W-1:0] io_oe,
  input logic              irq
);
  for (genvar k = 0; k < 3; k++) begin : g_k
    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(k)) |=> io_out[k] == $past(wdata));
    p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(k + 4)) |=> io_oe[k] == $past(wdata));
  end

  p_dir_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADDR_W'(4) && addr <= ADDR_W'(6)) |-> rdata == '1);

  p_inp_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(3)) |=> ($stable(io_out) && $stable(io_oe)));

  p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(7) && !wdata[0]) |=> !irq);

  p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADDR_W'(8)) |-> rdata == '0);

  p_unimpl_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr >= ADDR_W'(8)) |=> ($stable(io_out) && $stable(io_oe) && $stable(irq)));
endmodule

bind pport_bank pport_bank_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
  .rdata(rdata), .io_out(io_out), .io_oe(io_oe), .irq(irq)
);

// File: tb/pport_bank_tb_top.sv
`timescale 1ns/1ps
module pport_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 1'b0;
  logic [7:0] rdata;
  logic [2:0][7:0] io_in = '0;
  logic [7:0] in_pins = '0;
  logic [2:0][7:0] io_out, io_oe;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pport_bank dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .io_in(io_in), .in_pins(in_pins), .io_out(io_out),
    .io_oe(io_oe), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #0.5; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 io_out", io_out[0] | io_out[1] | io_out[2], 8'h00);
    chk("R1 io_oe", io_oe[0] | io_oe[1] | io_oe[2], 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(4'd7, v); chk("R1 ctrl", v, 8'h00);
  endtask

  task automatic t_bidir;
    logic [7:0] v;
    wr(4'd4, 8'hF0); wr(4'd0, 8'hA5);
    chk("R2 out0", io_out[0], 8'hA5);
    chk("R2 oe0", io_oe[0], 8'hF0);
    io_in[0] = 8'h3C; idle(3);
    rd(4'd0, v); chk("R3 mixed port0", v, 8'hAC);
    wr(4'd6, 8'hFF); wr(4'd2, 8'h5A);
    chk("R2 oe2", io_oe[2], 8'hFF);
    rd(4'd2, v); chk("R3 output port2", v, 8'h5A);
    @(negedge clk); io_in[1] = 8'hFF;
    rd(4'd1, v); chk("R3 one edge", v, 8'h00);
    rd(4'd1, v); chk("R3 two edges", v, 8'hFF);
  endtask

  task automatic t_dir;
    logic [7:0] v;
    rd(4'd4, v); chk("R4 dir0", v, 8'hFF);
    rd(4'd5, v); chk("R4 dir1", v, 8'hFF);
    rd(4'd6, v); chk("R4 dir2", v, 8'hFF);
  endtask

  task automatic t_inp;
    logic [7:0] v;
    in_pins = 8'h81; idle(3);
    rd(4'd3, v); chk("R5 input port", v, 8'h81);
    wr(4'd3, 8'h00);
    chk("R5 out0 kept", io_out[0], 8'hA5);
    chk("R5 oe0 kept", io_oe[0], 8'hF0);
    rd(4'd3, v); chk("R5 input kept", v, 8'h81);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    in_pins = 8'h40; idle(4);
    in_pins = 8'h00; idle(4);
    rd(4'd7, v); chk("R8 fall while disabled", v, 8'h00);
    wr(4'd7, 8'hFD);
    rd(4'd7, v); chk("R6 upper bits zero", v, 8'h01);
    in_pins = 8'h40; idle(4);
    rd(4'd7, v); chk("R8 rise ignored", v, 8'h01);
    chk("R8 irq low", {7'd0, irq}, 8'h00);
    in_pins = 8'h00; idle(4);
    rd(4'd7, v); chk("R6 pending set", v, 8'h03);
    chk("R6 irq high", {7'd0, irq}, 8'h01);
    wr(4'd7, 8'h03);
    rd(4'd7, v); chk("R7 write one keeps", v, 8'h03);
    wr(4'd7, 8'h01);
    rd(4'd7, v); chk("R7 cleared", v, 8'h01);
    chk("R7 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] v;
    in_pins = 8'h40; idle(4);
    in_pins = 8'h00;
    @(negedge clk); @(negedge clk);
    addr = 4'd7; wdata = 8'h01; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(4'd7, v); chk("R9 set wins", v, 8'h03);
    wr(4'd7, 8'h01);
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    for (int a = 8; a < 16; a++) wr(4'(a), 8'hFF);
    for (int a = 8; a < 16; a++) begin
      rd(4'(a), v); chk("R10 reads zero", v, 8'h00);
    end
    chk("R10 out0 kept", io_out[0], 8'hA5);
    chk("R10 oe1 kept", io_oe[1], 8'h00);
    rd(4'd7, v); chk("R10 ctrl kept", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bidir();
    t_dir();
    t_inp();
    t_irq();
    t_race();
    t_unimpl();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule